// File: doc/BRIEF.md
# Double-Buffered Clock Register Port

This block is the byte-wide access port of a timekeeping memory. It decodes an 11-bit address with active-low chip, output and write strobes. Most of the address space reaches a plain byte store. The eight highest addresses reach a bank of clock registers instead. Software never sees the running time count itself. It reads a second, visible copy of that count. The copy is refreshed as a whole, in one clock cycle, one cycle after each one-second tick.

Bit 6 of the control/century register is a hold control. Setting it freezes the visible copy, so software can read several time fields that belong together. The external counter keeps running while the copy is frozen. Clearing the bit does not refresh the copy at once: the copy reloads on the first tick after the release. While the copy is live, a write to a clock register is sent to the external counter as a one-cycle load strobe. A power-fail input deselects the port completely.

The counter itself lives outside this block. It delivers its eight bytes on `live_time` and takes loads on `ld_en`/`ld_byte`.

Top module: `rtc_dbuf_port`

## Requirements
- R1: After a synchronous active-low reset, `dq_oe` and `ld_en` are 0, the hold bit is 0 and all visible clock bytes are 0.
- R2: The bus is not driven in the cycle after either of these: `ce_n` is high, or `oe_n` and `we_n` are both high. In those cycles no write takes place.
- R3: A write takes place at the clock edge where `ce_n`=0 and `we_n`=0, whatever `oe_n` is. An address below 0x7F8 stores `dq_in` in the byte store, and the port does not drive the bus in the following cycle.
- R4: When `ce_n`=0, `oe_n`=0, `we_n`=1 and `pwr_fail`=0 at an edge, `dq_oe` is 1 in the next cycle. `dq_out` then carries the addressed byte.
- R5: While `pwr_fail`=1 nothing is read, written or loaded. `dq_oe` stays 0 and stored bytes are unchanged.
- R6: Address 0x7F8+i selects clock byte i, which is byte i of `live_time` (bits 8i+7..8i). The order is: 0 control/century, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day of month, 6 month, 7 year. Byte 0 keeps only bits 5:0 as the century. When read, it returns bit 7 = 0 and bit 6 = the hold bit.
- R7: The hold bit is written through bit 6 of 0x7F8. While it is 1, no visible byte changes, even when ticks arrive.
- R8: While the hold bit is 0, all eight visible bytes take `live_time` (byte 0 masked to bits 5:0) at the edge one cycle after an edge that sampled `sec_tick`=1. After a release the copy keeps its frozen values until that happens.
- R9: A write to clock byte i while the hold bit is 0 does three things. It raises `ld_en` with only bit i set for one cycle. It puts the written value on `ld_byte` (masked to bits 5:0 for byte 0). It puts the same value in the visible copy, so it reads back at once.
- R10: While the hold bit is 1, writes to clock bytes raise no load and change no visible byte. A write to 0x7F8 then changes only the hold bit.
- R11: A read of any clock byte returns a value from one consistent capture. A seconds rollover shows the new minute together with the zero seconds, never a mix.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| pwr_fail | input | 1 | Supply out of tolerance; forces deselect |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Read data, valid when dq_oe is 1 |
| dq_oe | output | 1 | Bus drive enable |
| sec_tick | input | 1 | One-cycle pulse each second from the counter |
| live_time | input | 64 | Running count, byte i at bits 8i+7..8i |
| ld_en | output | 8 | One-hot load strobe toward the counter |
| ld_byte | output | 8 | Load value toward the counter |

## Verification
The bound checker covers the strobe rules on every cycle. It confirms that deselect, idle strobes and power-fail leave the bus undriven, that a valid read always drives it, and that load strobes are one-hot and appear only after an enabled write. It also confirms that a set hold bit both freezes the visible copy and suppresses loads. Other behaviour depends on the contents of earlier writes and on tick history, so only the bench's scenarios show it: delayed reload after a release, masking of the century byte, rollover consistency and byte-store contents. Those scenarios are compared cycle by cycle against a behavioural model, including a long random mix of strobes, ticks and power-fail.

// File: rtl/rtc_dbuf_pkg.sv
// Shared constants and types for the double-buffered clock register port.
// Assumes an 8-bit data path and eight clock registers at the top of the map.
package rtc_dbuf_pkg;
    localparam int DATA_W   = 8;
    localparam int REG_CNT  = 8;
    localparam int IDX_W    = $clog2(REG_CNT);
    localparam int HALT_POS = 6;
    localparam logic [DATA_W-1:0] CENT_KEEP = 8'h3F;
    localparam logic [DATA_W-1:0] HALT_MASK = DATA_W'(1) << HALT_POS;

    typedef enum logic [IDX_W-1:0] {
        RI_CTRL, RI_SEC, RI_MIN, RI_HOUR, RI_WDAY, RI_MDAY, RI_MONTH, RI_YEAR
    } reg_idx_e;

    // Bits a clock byte keeps: byte 0 holds only the century field.
    function automatic logic [DATA_W-1:0] keep_mask(input logic [IDX_W-1:0] idx);
        return (idx == RI_CTRL) ? CENT_KEEP : {DATA_W{1'b1}};
    endfunction
endpackage

// File: rtl/rtc_bus_strobe.sv
// Strobe and address decode. Purely combinational.
// Assumes strobes are already synchronous to clk; power-fail overrides everything.
module rtc_bus_strobe #(
    parameter int ADDR_W = 11,
    parameter int IDX_W  = 3
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              pwr_fail,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_go,
    output logic              wr_go,
    output logic              clk_sel,
    output logic [IDX_W-1:0]  reg_idx
);
    logic selected;

    // Qualify strobes and split the address into region and register index.
    always_comb begin
        selected = !ce_n && !pwr_fail;
        wr_go    = selected && !we_n;
        rd_go    = selected && we_n && !oe_n;
        clk_sel  = &addr[ADDR_W-1:IDX_W];
        reg_idx  = addr[IDX_W-1:0];
    end
endmodule

// File: rtl/rtc_byte_store.sv
// Plain byte storage with a registered read port.
// Assumes the caller never writes the clock region; contents are not reset.
module rtc_byte_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Single port: write or registered read on each edge.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wdata;
        end
        if (rd_en) begin
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/rtc_shadow_regs.sv
// Visible copy of the running count, hold control and counter load strobes.
// Assumes the external counter updates live_time at the edge that samples
// sec_tick, so the copy is taken one edge later.
module rtc_shadow_regs
    import rtc_dbuf_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sec_tick,
    input  logic [REG_CNT*DATA_W-1:0] live_time,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          idx,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rd_byte,
    output logic [REG_CNT-1:0]        ld_en,
    output logic [DATA_W-1:0]         ld_byte,
    output logic                      halt,
    output logic [REG_CNT*DATA_W-1:0] vis_flat
);
    logic tick_q;
    logic halt_q;
    logic live_wr;

    assign live_wr = wr_en && !halt_q;
    assign halt    = halt_q;

    // Delay the tick so the copy sees the counter's new value.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= sec_tick;
    end

    // Hold bit lives in bit HALT_POS of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)                       halt_q <= 1'b0;
        else if (wr_en && idx == RI_CTRL) halt_q <= wdata[HALT_POS];
    end

    for (genvar g = 0; g < REG_CNT; g++) begin : g_vis
        localparam logic [DATA_W-1:0] KEEP = (g == 0) ? CENT_KEEP : {DATA_W{1'b1}};
        logic [DATA_W-1:0] q;

        // One visible byte: direct write wins over the tick capture.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (live_wr && idx == IDX_W'(g))
                q <= wdata & KEEP;
            else if (tick_q && !halt_q)
                q <= live_time[g*DATA_W +: DATA_W] & KEEP;
        end

        assign vis_flat[g*DATA_W +: DATA_W] = q;
    end

    // Read mux; the control byte reports the hold bit in its own position.
    always_comb begin
        rd_byte = vis_flat[int'(idx)*DATA_W +: DATA_W];
        if (idx == RI_CTRL && halt_q) rd_byte = rd_byte | HALT_MASK;
    end

    // One-cycle load strobe toward the running counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_en   <= '0;
            ld_byte <= '0;
        end else begin
            ld_en <= '0;
            if (live_wr) begin
                ld_en   <= REG_CNT'(1) << idx;
                ld_byte <= wdata & keep_mask(idx);
            end
        end
    end
endmodule

// File: rtl/rtc_dbuf_port.sv
// Top of the double-buffered clock register port: decode, byte store,
// visible clock copy and a registered output stage.
// Assumes all inputs are synchronous to clk; read data appears one cycle
// after the read strobes are sampled.
module rtc_dbuf_port
    import rtc_dbuf_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ce_n,
    input  logic                      oe_n,
    input  logic                      we_n,
    input  logic                      pwr_fail,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         dq_in,
    output logic [DATA_W-1:0]         dq_out,
    output logic                      dq_oe,
    input  logic                      sec_tick,
    input  logic [REG_CNT*DATA_W-1:0] live_time,
    output logic [REG_CNT-1:0]        ld_en,
    output logic [DATA_W-1:0]         ld_byte
);
    logic              rd_go, wr_go, clk_sel;
    logic [IDX_W-1:0]  reg_idx;
    logic [DATA_W-1:0] ram_q, clk_rd, clk_q;
    logic              oe_q, sel_q;
    logic              halt_w;
    logic [REG_CNT*DATA_W-1:0] vis_flat_w;

    rtc_bus_strobe #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_strobe (
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .pwr_fail(pwr_fail),
        .addr(addr), .rd_go(rd_go), .wr_go(wr_go),
        .clk_sel(clk_sel), .reg_idx(reg_idx)
    );

    rtc_byte_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .wr_en(wr_go && !clk_sel), .rd_en(rd_go && !clk_sel),
        .addr(addr), .wdata(dq_in), .rdata(ram_q)
    );

    rtc_shadow_regs u_shadow (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .live_time(live_time),
        .wr_en(wr_go && clk_sel), .idx(reg_idx), .wdata(dq_in),
        .rd_byte(clk_rd), .ld_en(ld_en), .ld_byte(ld_byte),
        .halt(halt_w), .vis_flat(vis_flat_w)
    );

    // Output stage: remember drive, region and clock byte of the last read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q  <= 1'b0;
            sel_q <= 1'b0;
            clk_q <= '0;
        end else begin
            oe_q <= rd_go;
            if (rd_go) begin
                sel_q <= clk_sel;
                clk_q <= clk_rd;
            end
        end
    end

    assign dq_oe  = oe_q;
    assign dq_out = oe_q ? (sel_q ? clk_q : ram_q) : '0;
endmodule

// File: rtl/rtc_dbuf_chk.sv
// Protocol checker for rtc_dbuf_port, attached by bind below.
// Assumes the default 8 clock bytes of 8 bits.
module rtc_dbuf_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ce_n,
    input logic        oe_n,
    input logic        we_n,
    input logic        pwr_fail,
    input logic        dq_oe,
    input logic [7:0]  ld_en,
    input logic        halt_w,
    input logic [63:0] vis_flat_w
);
    // R2
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !dq_oe);
    // R2
    idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && we_n) |=> !dq_oe);
    // R4
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n && !pwr_fail) |=> dq_oe);
    // R5
    pwr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (!dq_oe && ld_en == 8'h00));
    // R9
    load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_en));
    // R9
    load_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || we_n || pwr_fail) |=> ld_en == 8'h00);
    // R7
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_w |=> $stable(vis_flat_w));
    // R10
    halt_noload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_w |=> ld_en == 8'h00);
endmodule

bind rtc_dbuf_port rtc_dbuf_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .pwr_fail(pwr_fail), .dq_oe(dq_oe), .ld_en(ld_en),
    .halt_w(halt_w), .vis_flat_w(vis_flat_w)
);

// File: tb/sim_rtc_dbuf_port.sv
// Bench: behavioural model of the port plus a simple external counter,
// compared on every clock, followed by directed checks per requirement.
module sim_rtc_dbuf_port;
    localparam int CLK_NS   = 10;
    localparam int ADDR_W   = 11;
    localparam int CLK_BASE = (1 << ADDR_W) - 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, pwr_fail = 1'b0, sec_tick = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] dq_in = '0;
    logic [7:0] dq_out, ld_byte, ld_en;
    logic dq_oe;
    logic [7:0] live [8];
    logic [63:0] live_time;

    int total = 0, bad = 0;
    string cur_req = "R1";
    bit cmp_on = 0;

    always #(CLK_NS/2) clk = ~clk;

    rtc_dbuf_port #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .pwr_fail(pwr_fail), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .sec_tick(sec_tick), .live_time(live_time),
        .ld_en(ld_en), .ld_byte(ld_byte)
    );

    // External running counter: seconds roll into minutes, loads override.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) live[i] <= 8'h00;
        end else begin
            if (sec_tick) begin
                if (live[1] == 8'd59) begin
                    live[1] <= 8'd0;
                    live[2] <= live[2] + 8'd1;
                end else begin
                    live[1] <= live[1] + 8'd1;
                end
            end
            for (int i = 0; i < 8; i++) if (ld_en[i]) live[i] <= ld_byte;
        end
    end

    always_comb for (int i = 0; i < 8; i++) live_time[8*i +: 8] = live[i];

    function automatic logic [7:0] kmask(int i);
        return (i == 0) ? 8'h3F : 8'hFF;
    endfunction

    // Behavioural reference model.
    bit m_halt, m_tq, m_oe, m_known, m_rd, m_wr;
    int m_idx;
    logic [7:0] m_out, m_ldb, m_ld;
    logic [7:0] m_vis [8];
    logic [7:0] nv [8];
    logic [7:0] m_mem [int];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_halt = 0; m_tq = 0; m_oe = 0; m_known = 0; m_ld = 8'h00;
            for (int i = 0; i < 8; i++) m_vis[i] = 8'h00;
        end else begin
            m_rd  = !ce_n && !oe_n && we_n && !pwr_fail;
            m_wr  = !ce_n && !we_n && !pwr_fail;
            m_idx = int'(addr) - CLK_BASE;
            m_oe  = m_rd;
            m_known = 0;
            if (m_rd) begin
                if (m_idx >= 0) begin
                    m_out = m_vis[m_idx] | ((m_idx == 0 && m_halt) ? 8'h40 : 8'h00);
                    m_known = 1;
                end else if (m_mem.exists(int'(addr))) begin
                    m_out = m_mem[int'(addr)];
                    m_known = 1;
                end
            end
            for (int i = 0; i < 8; i++)
                nv[i] = (m_tq && !m_halt) ? (live[i] & kmask(i)) : m_vis[i];
            m_ld = 8'h00;
            if (m_wr) begin
                if (m_idx < 0) m_mem[int'(addr)] = dq_in;
                else if (!m_halt) begin
                    nv[m_idx] = dq_in & kmask(m_idx);
                    m_ld  = 8'(1 << m_idx);
                    m_ldb = dq_in & kmask(m_idx);
                end
                if (m_idx == 0) m_halt = dq_in[6];
            end
            for (int i = 0; i < 8; i++) m_vis[i] = nv[i];
            m_tq = sec_tick;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            total++;
            if (dq_oe !== m_oe) begin
                bad++;
                $display("FAIL %s model dq_oe got %b exp %b", cur_req, dq_oe, m_oe);
            end
            if (m_oe && m_known) begin
                total++;
                if (dq_out !== m_out) begin
                    bad++;
                    $display("FAIL %s model dq_out got %h exp %h", cur_req, dq_out, m_out);
                end
            end
            total++;
            if (ld_en !== m_ld) begin
                bad++;
                $display("FAIL %s model ld_en got %h exp %h", cur_req, ld_en, m_ld);
            end
            if (m_ld != 8'h00) begin
                total++;
                if (ld_byte !== m_ldb) begin
                    bad++;
                    $display("FAIL %s model ld_byte got %h exp %h", cur_req, ld_byte, m_ldb);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic idle_cyc(input int n);
        repeat (n) begin
            @(negedge clk);
            ce_n = 1; oe_n = 1; we_n = 1; sec_tick = 0;
        end
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d, input logic oe_v);
        @(negedge clk);
        ce_n = 0; we_n = 0; oe_n = oe_v; addr = a; dq_in = d; sec_tick = 0;
        @(negedge clk);
        ce_n = 1; we_n = 1; oe_n = 1;
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [7:0] v, output logic seen);
        @(negedge clk);
        ce_n = 0; oe_n = 0; we_n = 1; addr = a; sec_tick = 0;
        @(negedge clk);
        v = dq_out; seen = dq_oe;
        ce_n = 1; oe_n = 1;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        ce_n = 1; oe_n = 1; we_n = 1; sec_tick = 1;
        @(negedge clk);
        sec_tick = 0;
    endtask

    task automatic run_all();
        logic [7:0] v;
        logic seen;
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_on = 1;

        cur_req = "R1";
        chk("R1 dq_oe after reset", 8'(dq_oe), 8'h00);
        chk("R1 ld_en after reset", ld_en, 8'h00);
        bus_rd(11'(CLK_BASE), v, seen);
        chk("R1 control byte after reset", v, 8'h00);
        chk("R4 read drives bus", 8'(seen), 8'h01);

        cur_req = "R3";
        bus_wr(11'h000, 8'h5A, 1'b1);
        bus_wr(11'h123, 8'hC3, 1'b0);
        chk("R3 no drive after write with oe_n low", 8'(dq_oe), 8'h00);
        bus_wr(11'h7F7, 8'h99, 1'b0);
        bus_rd(11'h000, v, seen); chk("R3 read 0x000", v, 8'h5A);
        bus_rd(11'h123, v, seen); chk("R3 read 0x123", v, 8'hC3);
        bus_rd(11'h7F7, v, seen); chk("R3 read 0x7F7", v, 8'h99);

        cur_req = "R2";
        @(negedge clk); ce_n = 1; we_n = 0; addr = 11'h123; dq_in = 8'h00;
        @(negedge clk); we_n = 1;
        chk("R2 no drive when deselected", 8'(dq_oe), 8'h00);
        bus_rd(11'h123, v, seen); chk("R2 deselected write ignored", v, 8'hC3);
        @(negedge clk); ce_n = 0; oe_n = 1; we_n = 1; addr = 11'h123;
        @(negedge clk); ce_n = 1;
        chk("R2 idle strobes leave bus undriven", 8'(dq_oe), 8'h00);

        cur_req = "R5";
        pwr_fail = 1;
        bus_wr(11'h123, 8'h11, 1'b1);
        chk("R5 no load under power fail", ld_en, 8'h00);
        bus_rd(11'h123, v, seen);
        chk("R5 no drive under power fail", 8'(seen), 8'h00);
        pwr_fail = 0;
        bus_rd(11'h123, v, seen); chk("R5 blocked write left data", v, 8'hC3);

        cur_req = "R9";
        for (int i = 1; i < 8; i++) begin
            bus_wr(11'(CLK_BASE + i), 8'(8'h10 + i), 1'b1);
            chk("R9 one-hot load strobe", ld_en, 8'(1 << i));
            chk("R9 load value", ld_byte, 8'(8'h10 + i));
            bus_rd(11'(CLK_BASE + i), v, seen);
            chk("R6 clock byte read back", v, 8'(8'h10 + i));
        end
        bus_wr(11'(CLK_BASE), 8'h94, 1'b1);
        chk("R9 century load strobe", ld_en, 8'h01);
        chk("R9 century load masked", ld_byte, 8'h14);
        bus_rd(11'(CLK_BASE), v, seen);
        chk("R6 century read masked", v, 8'h14);

        cur_req = "R8";
        pulse_tick();
        idle_cyc(2);
        bus_rd(11'(CLK_BASE + 1), v, seen);
        chk("R8 copy reloaded after tick", v, 8'h12);

        cur_req = "R7";
        bus_wr(11'(CLK_BASE), 8'h54, 1'b1);
        bus_rd(11'(CLK_BASE), v, seen);
        chk("R7 hold bit reads back", v, 8'h54);
        repeat (5) pulse_tick();
        idle_cyc(2);
        bus_rd(11'(CLK_BASE + 1), v, seen);
        chk("R7 seconds frozen while held", v, 8'h12);

        cur_req = "R10";
        bus_wr(11'(CLK_BASE + 1), 8'h33, 1'b1);
        chk("R10 no load while held", ld_en, 8'h00);
        bus_rd(11'(CLK_BASE + 1), v, seen);
        chk("R10 held write ignored", v, 8'h12);
        bus_wr(11'(CLK_BASE), 8'h60, 1'b1);
        chk("R10 no century load while held", ld_en, 8'h00);
        bus_rd(11'(CLK_BASE), v, seen);
        chk("R10 century unchanged while held", v, 8'h54);

        cur_req = "R8";
        bus_wr(11'(CLK_BASE), 8'h14, 1'b1);
        chk("R8 release write loads nothing", ld_en, 8'h00);
        bus_rd(11'(CLK_BASE + 1), v, seen);
        chk("R8 copy held until tick", v, 8'h12);
        idle_cyc(3);
        bus_rd(11'(CLK_BASE + 1), v, seen);
        chk("R8 copy still held without tick", v, 8'h12);
        pulse_tick();
        idle_cyc(2);
        bus_rd(11'(CLK_BASE + 1), v, seen);
        chk("R8 copy reloaded on tick after release", v, 8'h18);

        cur_req = "R11";
        bus_wr(11'(CLK_BASE + 1), 8'd59, 1'b1);
        bus_wr(11'(CLK_BASE + 2), 8'd5, 1'b1);
        pulse_tick();
        bus_wr(11'(CLK_BASE), 8'h54, 1'b1);
        repeat (3) pulse_tick();
        bus_rd(11'(CLK_BASE + 1), v, seen);
        chk("R11 rollover seconds", v, 8'd0);
        bus_rd(11'(CLK_BASE + 2), v, seen);
        chk("R11 rollover minutes", v, 8'd6);
        bus_wr(11'(CLK_BASE), 8'h14, 1'b1);

        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            ce_n     = ($urandom % 5) == 0;
            oe_n     = $urandom % 2;
            we_n     = ($urandom % 3) != 0;
            pwr_fail = ($urandom % 16) == 0;
            sec_tick = ($urandom % 4) == 0;
            addr     = ($urandom % 2) ? 11'(CLK_BASE + ($urandom % 8))
                                      : 11'($urandom % 64);
            dq_in    = 8'($urandom);
        end
        pwr_fail = 0;
        idle_cyc(3);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (50000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired in %s", cur_req);
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule